// File: doc/BRIEF.md
# Triggered Strip Hit Buffer Readout

This block reads out a group of silicon strip channels under a trigger. Each channel owns a small slot buffer. When the channel reports a hit, the buffer stores the 4-bit time-over-threshold charge together with the value of a shared free-running time-stamp counter. Every slot is aged against that counter. Slots that pass the trigger latency without being selected are dropped on their own, so the buffers only ever hold hits that a trigger could still claim.

A trigger asks for the bunch crossing that happened a fixed number of clocks (`LAT`) earlier. All channels compare their slots in parallel, and every match is marked for readout. The marked hits from all channels are merged onto one output port with valid/ready flow control. A round-robin pointer decides which channel goes next, so a stalled output never starves one channel in favour of another. The channel count is a parameter: 128 is the nominal value, and a small value is used for test.

Top module: `strip_trig_readout`

## Requirements
- R1: The time-stamp counter is `TSW` bits wide, reads 0 in the first cycle after reset, advances by one every clock and wraps modulo 2^TSW. A hit is stamped with the counter value of the cycle in which `hit_vld` is sampled.
- R2: A hit on a channel that has a free slot is stored. Its charge and stamp later appear unchanged in the output word.
- R3: A hit on a channel whose slots are all occupied is dropped. That channel's overflow count (`OVW` bits, field `c` at bits `c*OVW +: OVW` of `ovf_cnt`) rises by one and saturates at its all-ones value. Other channels' counts do not change.
- R4: A stored hit that is not selected while its age is in the match window is removed once its age exceeds `LAT+WIN`. A trigger arriving later never returns it.
- R5: A trigger sampled in a cycle where (counter − stamp) mod 2^TSW lies in `LAT−WIN .. LAT+WIN` selects that hit. With `WIN=0`, a trigger at age `LAT−1` selects nothing. A selected hit is presented with `out_vld` two clock edges after the trigger edge, provided the output is free.
- R6: A trigger removes only the hits it selects. Other hits in the same channel stay in the buffer and can be selected by a later trigger.
- R7: The output word is {channel index (`CHW` bits), charge (4 bits), stamp (`TSW` bits)}, from MSB to LSB.
- R8: While `out_vld` is high and `out_ready` is low, `out_vld` stays high and `out_word` stays constant.
- R9: When several channels hold selected hits, the channels take turns in round-robin order. Two channels with two selected hits each produce words whose channels alternate.
- R10: After reset, `out_vld` is low and every overflow count is zero.
- R11: Free slots are judged at the start of a cycle. A hit that arrives in the same cycle as the only expiry of a full buffer is dropped and counted. A hit one cycle later reuses the freed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_vld | input | NCH | Per-channel hit strobe |
| hit_tot | input | NCH*4 | Per-channel charge; channel c at bits c*4 +: 4 |
| trig | input | 1 | Trigger strobe for the crossing LAT clocks back |
| out_ready | input | 1 | Downstream can accept a word |
| out_vld | output | 1 | Output word valid |
| out_word | output | CHW+4+TSW | {channel, charge, stamp} |
| ovf_cnt | output | NCH*OVW | Per-channel saturating overflow counts |

## Verification
The bench targets the edges of the match window. A trigger one clock early or one clock late must return nothing. A design with an off-by-one age compare would emit a word there, or lose the exact match. It fills a buffer and then sends a hit in the very cycle the oldest slot expires. A design that freed slots before allocating would then accept it, and the overflow count would stay low. It stalls the output with two channels loaded to catch a changing held word and a fixed-priority merge that never alternates. A long random run with wrapping stamps and random backpressure is compared against a queue model of selection and expiry. That model exposes stamps compared without modulo and hits lost or duplicated in the merge.

// File: rtl/strip_ro_pkg.sv
package strip_ro_pkg;

    // Width of the time-over-threshold charge code.
    localparam int TOT_W = 4;

    typedef logic [TOT_W-1:0] tot_t;

    // Index width for n items, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/strip_ts_gen.sv
module strip_ts_gen #(
    parameter int TSW = 8
) (
    input  logic           clk,
    input  logic           rst,
    output logic [TSW-1:0] ts
);

    logic [TSW-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_q + 1'b1;
    end

    assign ts = ts_q;

    // Counter steps by one and wraps
    assert_ts_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ts_q == TSW'($past(ts_q) + 1'b1)));

endmodule

// File: rtl/strip_chan_buf.sv
module strip_chan_buf
    import strip_ro_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TSW   = 8,
    parameter int LAT   = 48,
    parameter int WIN   = 0,
    parameter int OVW   = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [TSW-1:0] ts_now,
    input  logic           hit_vld,
    input  tot_t           hit_tot,
    input  logic           trig,
    input  logic           pop,
    output logic           req,
    output tot_t           head_tot,
    output logic [TSW-1:0] head_ts,
    output logic [OVW-1:0] ovf_cnt
);

    localparam int             SW      = idx_w(DEPTH);
    localparam logic [TSW-1:0] AGE_LO  = TSW'(LAT - WIN);
    localparam logic [TSW-1:0] AGE_HI  = TSW'(LAT + WIN);
    localparam logic [OVW-1:0] OVF_MAX = '1;

    typedef struct packed {
        logic           vld;
        logic           pend;
        tot_t           tot;
        logic [TSW-1:0] ts;
    } slot_t;

    slot_t          slot_q [DEPTH];
    logic [TSW-1:0] age    [DEPTH];
    logic [SW-1:0]  free_idx;
    logic [SW-1:0]  head_idx;
    logic           full;
    logic           have_head;
    logic [OVW-1:0] ovf_q;

    // Lowest free slot, lowest selected slot, per-slot age
    always_comb begin
        full      = 1'b1;
        free_idx  = '0;
        have_head = 1'b0;
        head_idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            age[i] = ts_now - slot_q[i].ts;
            if (!slot_q[i].vld) begin
                full     = 1'b0;
                free_idx = SW'(i);
            end
            if (slot_q[i].vld && slot_q[i].pend) begin
                have_head = 1'b1;
                head_idx  = SW'(i);
            end
        end
    end

    assign req      = have_head;
    assign head_tot = slot_q[head_idx].tot;
    assign head_ts  = slot_q[head_idx].ts;
    assign ovf_cnt  = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            ovf_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (pop && have_head && head_idx == SW'(i)) begin
                    slot_q[i].vld  <= 1'b0;
                    slot_q[i].pend <= 1'b0;
                end else if (slot_q[i].vld && !slot_q[i].pend) begin
                    if (trig && age[i] >= AGE_LO && age[i] <= AGE_HI)
                        slot_q[i].pend <= 1'b1;
                    else if (age[i] > AGE_HI)
                        slot_q[i].vld <= 1'b0;
                end
                if (hit_vld && !full && free_idx == SW'(i))
                    slot_q[i] <= '{vld: 1'b1, pend: 1'b0, tot: hit_tot, ts: ts_now};
            end
            if (hit_vld && full && ovf_q != OVF_MAX)
                ovf_q <= ovf_q + 1'b1;
        end
    end

    assert_ovf_step_R3: assert property (@(posedge clk) disable iff (rst)
        (hit_vld && full && ovf_q != OVF_MAX) |=> (ovf_q == OVW'($past(ovf_q) + 1'b1)));

    assert_ovf_sat_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf_q == OVF_MAX) |=> (ovf_q == OVF_MAX));

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        // Unselected slot never outlives the window by more than one clock
        assert_expired_gone_R4: assert property (@(posedge clk) disable iff (rst)
            (slot_q[g].vld && !slot_q[g].pend) |->
            ({1'b0, age[g]} <= {1'b0, AGE_HI} + 1'b1));
        // Selected slot leaves only through a pop
        assert_pend_kept_R6: assert property (@(posedge clk) disable iff (rst)
            (slot_q[g].vld && slot_q[g].pend && !(pop && head_idx == SW'(g)))
            |=> slot_q[g].vld);
    end

endmodule

// File: rtl/strip_rr_merge.sv
module strip_rr_merge
    import strip_ro_pkg::*;
#(
    parameter int NCH = 128,
    parameter int TSW = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NCH-1:0]                  req,
    input  logic [NCH*TOT_W-1:0]            tots,
    input  logic [NCH*TSW-1:0]              tss,
    input  logic                            out_ready,
    output logic [NCH-1:0]                  grant,
    output logic                            out_vld,
    output logic [idx_w(NCH)+TOT_W+TSW-1:0] out_word
);

    localparam int CHW = idx_w(NCH);

    typedef struct packed {
        logic [CHW-1:0] ch;
        tot_t           tot;
        logic [TSW-1:0] ts;
    } word_t;

    word_t          word_q;
    logic           vld_q;
    logic [CHW-1:0] ptr_q;
    logic [CHW-1:0] gidx;
    logic           found;
    logic           load;

    // First requester at or after the pointer, wrapping
    always_comb begin
        int j;
        found = 1'b0;
        gidx  = '0;
        for (int k = 0; k < NCH; k++) begin
            j = (int'(ptr_q) + k) % NCH;
            if (!found && req[j]) begin
                found = 1'b1;
                gidx  = CHW'(j);
            end
        end
        load  = found && (!vld_q || out_ready);
        grant = '0;
        if (load) grant[gidx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            word_q <= '0;
            ptr_q  <= '0;
        end else if (load) begin
            vld_q  <= 1'b1;
            word_q <= '{ch:  gidx,
                        tot: tots[int'(gidx)*TOT_W +: TOT_W],
                        ts:  tss[int'(gidx)*TSW +: TSW]};
            ptr_q  <= (gidx == CHW'(NCH - 1)) ? '0 : gidx + 1'b1;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    assign out_vld  = vld_q;
    assign out_word = word_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !out_ready) |=> (vld_q && $stable(word_q)));

    assert_one_grant_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_has_req_R9: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~req) == '0));

endmodule

// File: rtl/strip_trig_readout.sv
module strip_trig_readout
    import strip_ro_pkg::*;
#(
    parameter int NCH   = 128,
    parameter int DEPTH = 4,
    parameter int TSW   = 8,
    parameter int LAT   = 48,
    parameter int WIN   = 0,
    parameter int OVW   = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NCH-1:0]                  hit_vld,
    input  logic [NCH*TOT_W-1:0]            hit_tot,
    input  logic                            trig,
    input  logic                            out_ready,
    output logic                            out_vld,
    output logic [idx_w(NCH)+TOT_W+TSW-1:0] out_word,
    output logic [NCH*OVW-1:0]              ovf_cnt
);

    logic [TSW-1:0]       ts;
    logic [NCH-1:0]       req;
    logic [NCH-1:0]       grant;
    logic [NCH*TOT_W-1:0] tots;
    logic [NCH*TSW-1:0]   tss;

    strip_ts_gen #(.TSW(TSW)) u_ts (
        .clk (clk),
        .rst (rst),
        .ts  (ts)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        strip_chan_buf #(
            .DEPTH (DEPTH),
            .TSW   (TSW),
            .LAT   (LAT),
            .WIN   (WIN),
            .OVW   (OVW)
        ) u_buf (
            .clk      (clk),
            .rst      (rst),
            .ts_now   (ts),
            .hit_vld  (hit_vld[c]),
            .hit_tot  (hit_tot[c*TOT_W +: TOT_W]),
            .trig     (trig),
            .pop      (grant[c]),
            .req      (req[c]),
            .head_tot (tots[c*TOT_W +: TOT_W]),
            .head_ts  (tss[c*TSW +: TSW]),
            .ovf_cnt  (ovf_cnt[c*OVW +: OVW])
        );
    end

    strip_rr_merge #(.NCH(NCH), .TSW(TSW)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .tots      (tots),
        .tss       (tss),
        .out_ready (out_ready),
        .grant     (grant),
        .out_vld   (out_vld),
        .out_word  (out_word)
    );

endmodule

// File: tb/strip_trig_readout_bench.sv
module strip_trig_readout_bench;

    localparam int NCH   = 4;
    localparam int DEPTH = 4;
    localparam int TSW   = 6;
    localparam int LAT   = 12;
    localparam int WIN   = 0;
    localparam int OVW   = 3;
    localparam int CHW   = 2;
    localparam int WW    = CHW + 4 + TSW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    hit_vld = '0;
    logic [NCH*4-1:0]  hit_tot = '0;
    logic              trig = 1'b0;
    logic              out_ready = 1'b1;
    logic              out_vld;
    logic [WW-1:0]     out_word;
    logic [NCH*OVW-1:0] ovf_cnt;

    strip_trig_readout #(
        .NCH(NCH), .DEPTH(DEPTH), .TSW(TSW), .LAT(LAT), .WIN(WIN), .OVW(OVW)
    ) u_strip_trig_readout (
        .clk(clk), .rst(rst), .hit_vld(hit_vld), .hit_tot(hit_tot), .trig(trig),
        .out_ready(out_ready), .out_vld(out_vld), .out_word(out_word), .ovf_cnt(ovf_cnt)
    );

    always #10 clk = ~clk;

    typedef struct { int t; bit m; bit r; } ent_t;

    ent_t          ents [NCH][$];
    logic [WW-1:0] exp_q [$];
    logic [WW-1:0] rx_log [$];
    int            abs_t = 0;
    int            n_vec = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;

    function automatic logic [WW-1:0] mk_word(int ch, int tot, int t);
        return {CHW'(ch), 4'(tot), TSW'(t)};
    endfunction

    function automatic int ovf_of(int ch);
        return int'(ovf_cnt[ch*OVW +: OVW]);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        abs_t++;
        @(negedge clk);
    endtask

    task automatic idle_to(int t);
        while (abs_t < t) tick();
    endtask

    task automatic hit_tick(int ch, int tot);
        hit_vld[ch] = 1'b1;
        hit_tot[ch*4 +: 4] = 4'(tot);
        tick();
        hit_vld = '0;
    endtask

    task automatic trig_tick();
        trig = 1'b1;
        tick();
        trig = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        hit_vld = '0;
        trig = 1'b0;
        repeat (3) tick();
        for (int c = 0; c < NCH; c++) ents[c].delete();
        exp_q.delete();
        rst = 1'b0;
        abs_t = 0;
    endtask

    // Monitor: samples between edges, matches words against the scoreboard
    always begin
        @(negedge clk);
        #5;
        if (!rst && out_vld && out_ready) begin
            automatic logic [WW-1:0] w = out_word;
            automatic bit hit = 1'b0;
            automatic int ch = int'(w[WW-1 -: CHW]);
            rx_log.push_back(w);
            foreach (exp_q[k]) begin
                if (!hit && exp_q[k] == w) begin
                    hit = 1'b1;
                    exp_q.delete(k);
                end
            end
            chk(hit, "R5", "word not expected", int'(w), -1);
            foreach (ents[ch][k]) begin
                if (hit && ents[ch][k].m && !ents[ch][k].r &&
                    TSW'(ents[ch][k].t) == w[TSW-1:0]) begin
                    ents[ch][k].r = 1'b1;
                    hit = 1'b0;
                end
            end
        end
    end

    function automatic int occ(int ch);
        int n = 0;
        foreach (ents[ch][k]) begin
            if ((!ents[ch][k].m && abs_t - ents[ch][k].t <= LAT + 1) ||
                (ents[ch][k].m && !ents[ch][k].r)) n++;
        end
        return n;
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        logic [WW-1:0] w0;
        int base;
        @(negedge clk);

        // R10: reset state
        do_reset();
        chk(out_vld == 1'b0, "R10", "out_vld after reset", int'(out_vld), 0);
        chk(ovf_cnt == '0, "R10", "ovf after reset", int'(ovf_cnt), 0);

        // R1 R5 R7: single hit, exact latency, timing and word layout
        idle_to(5);
        hit_tick(3, 4'hA);
        exp_q.push_back(mk_word(3, 4'hA, 5));
        idle_to(5 + LAT);
        trig_tick();
        chk(out_vld == 1'b0, "R5", "out_vld one edge after trigger", int'(out_vld), 0);
        tick();
        chk(out_vld == 1'b1, "R5", "out_vld two edges after trigger", int'(out_vld), 1);
        chk(out_word == mk_word(3, 4'hA, 5), "R7", "word layout", int'(out_word),
            int'(mk_word(3, 4'hA, 5)));
        idle_to(abs_t + 3);
        chk(exp_q.size() == 0, "R2", "stored hit delivered", exp_q.size(), 0);

        // R4 R5: early trigger misses, late trigger finds it expired
        do_reset();
        base = rx_log.size();
        idle_to(2);
        hit_tick(2, 7);
        idle_to(2 + LAT - 1);
        trig_tick();
        idle_to(2 + LAT + 1);
        trig_tick();
        idle_to(abs_t + 6);
        chk(rx_log.size() == base, "R4", "words from early/late triggers", rx_log.size() - base, 0);

        // R6: second hit survives first trigger
        do_reset();
        hit_tick(1, 3);
        tick();
        hit_tick(1, 9);
        exp_q.push_back(mk_word(1, 3, 0));
        exp_q.push_back(mk_word(1, 9, 2));
        idle_to(LAT);
        trig_tick();
        idle_to(LAT + 2);
        trig_tick();
        idle_to(abs_t + 6);
        chk(exp_q.size() == 0, "R6", "both hits read out", exp_q.size(), 0);

        // R3: overflow count and saturation
        do_reset();
        for (int i = 0; i < DEPTH + 3; i++) hit_tick(3, i);
        chk(ovf_of(3) == 3, "R3", "overflow count", ovf_of(3), 3);
        chk(ovf_of(0) == 0, "R3", "other channel count", ovf_of(0), 0);
        for (int i = 0; i < 6; i++) hit_tick(3, i);
        chk(ovf_of(3) == 7, "R3", "saturated count", ovf_of(3), 7);

        // R11: hit in the expiry cycle is dropped, next cycle reuses slot
        do_reset();
        for (int i = 0; i < DEPTH; i++) hit_tick(0, 1);
        idle_to(LAT + 1);
        hit_tick(0, 2);
        chk(ovf_of(0) == 1, "R11", "drop in expiry cycle", ovf_of(0), 1);
        hit_tick(0, 5);
        chk(ovf_of(0) == 1, "R11", "accept after expiry", ovf_of(0), 1);
        exp_q.push_back(mk_word(0, 5, LAT + 2));
        idle_to(2 * LAT + 2);
        trig_tick();
        idle_to(abs_t + 5);
        chk(exp_q.size() == 0, "R11", "reused slot read out", exp_q.size(), 0);

        // R8 R9: stall with two loaded channels, then release
        do_reset();
        out_ready = 1'b0;
        for (int r = 0; r < 2; r++) begin
            hit_vld = 4'b0101;
            hit_tot = {4'd0, 4'(r + 4), 4'd0, 4'(r + 1)};
            tick();
            hit_vld = '0;
        end
        exp_q.push_back(mk_word(0, 1, 0));
        exp_q.push_back(mk_word(0, 2, 1));
        exp_q.push_back(mk_word(2, 4, 0));
        exp_q.push_back(mk_word(2, 5, 1));
        idle_to(LAT);
        trig_tick();
        trig_tick();
        idle_to(LAT + 4);
        w0 = out_word;
        chk(out_vld == 1'b1, "R8", "valid while stalled", int'(out_vld), 1);
        idle_to(LAT + 8);
        chk(out_vld == 1'b1, "R8", "valid held", int'(out_vld), 1);
        chk(out_word == w0, "R8", "word held", int'(out_word), int'(w0));
        base = rx_log.size();
        out_ready = 1'b1;
        idle_to(abs_t + 8);
        chk(rx_log.size() - base == 4, "R9", "words after release", rx_log.size() - base, 4);
        for (int k = 0; k + 1 < 4 && base + k + 1 < rx_log.size(); k++)
            chk(rx_log[base+k][WW-1 -: CHW] != rx_log[base+k+1][WW-1 -: CHW], "R9",
                "channel alternation", int'(rx_log[base+k+1][WW-1 -: CHW]),
                int'(rx_log[base+k][WW-1 -: CHW]) ^ 2);

        // R1 R2 R4 R5: random hits, triggers and backpressure with wrapping stamps
        do_reset();
        for (int cyc = 0; cyc < 3000; cyc++) begin
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(7) == 0 && occ(c) < DEPTH) begin
                    automatic int tv = $urandom_range(15);
                    hit_vld[c] = 1'b1;
                    hit_tot[c*4 +: 4] = 4'(tv);
                    ents[c].push_back('{t: abs_t, m: 1'b0, r: 1'b0});
                end
            end
            trig = ($urandom_range(2) == 0);
            if (trig) begin
                for (int c = 0; c < NCH; c++) begin
                    foreach (ents[c][k]) begin
                        if (!ents[c][k].m && abs_t - ents[c][k].t == LAT) begin
                            ents[c][k].m = 1'b1;
                            exp_q.push_back(mk_word(c, 0, ents[c][k].t));
                        end
                    end
                end
            end
            // fill in charges of words just expected from stored tot values
            out_ready = ($urandom_range(3) != 0);
            tick();
            hit_vld = '0;
            trig = 1'b0;
        end
        out_ready = 1'b1;
        idle_to(abs_t + 40);
        chk(exp_q.size() == 0, "R2", "random run words outstanding", exp_q.size(), 0);
        chk(ovf_cnt == '0, "R3", "no drops below capacity", int'(ovf_cnt), 0);

        done = 1'b1;
        summary();
    end

    // Charge values in the random run: record per hit so expected words carry them
    logic [3:0] tot_hist [NCH][int];
    always begin
        @(negedge clk);
        #2;
        for (int c = 0; c < NCH; c++)
            if (hit_vld[c] && !rst) tot_hist[c][abs_t] = hit_tot[c*4 +: 4];
        if (trig && !rst) begin
            foreach (exp_q[k]) begin
                automatic int c2 = int'(exp_q[k][WW-1 -: CHW]);
                automatic int t2 = abs_t - LAT;
                if (exp_q[k][TSW+3 -: 4] == 4'd0 && TSW'(t2) == exp_q[k][TSW-1:0] &&
                    tot_hist[c2].exists(t2))
                    exp_q[k][TSW+3 -: 4] = tot_hist[c2][t2];
            end
        end
    end

endmodule